// File: doc/BRIEF.md
# Hibernate Wakeup and Reset Sequencer

This block sequences a chip's entry into and exit from a low-power hibernate state. It runs entirely on the slow 32 kHz oscillator clock, so every count is measured in oscillator ticks. Software asks for hibernation by writing a command register. From then on, a power-down output stays asserted until the wakeup pin has been held high long enough to pass a programmable glitch filter. The block then drives an active-low system reset for a programmable time and returns to normal operation.

Both tick counts come from restricted register fields. Only the upper bits of each count can be programmed, so the filter and the reset time always step in units of 32 ticks. A separate control register gates the 32 kHz clock onto an output pin and controls that pin's pull-up. All programming goes through a single-cycle register write port with a combinational read port.

Top module: `hib_wake_seq`

## Requirements
- R1: After reset, pwr_down_o is 0, sys_rst_no is 1, clk32_oe_o and pad_pull_dis_o are 0, and the registers at offsets 0x24, 0x28 and 0x40 read 0.
- R2: A write to offset 0x20 with bit 0 set, made while the block is running, raises pwr_down_o on the next tick. A write there with bit 0 clear, or any such write made while the block is not running, has no effect. Offset 0x20 reads 0.
- R3: The wake-filter register at offset 0x24 stores write-data bits 15:5 as the filter tick count F. All other bits read 0.
- R4: The reset-time register at offset 0x28 stores write-data bits 11:5 as the reset tick count T. All other bits read 0.
- R5: One tick after the hibernate command, the block enters the filter state and samples wake_i on every tick. It leaves the filter state on the (F+1)-th consecutive high sample, which is also the first high sample when F is 0. With wake_i held high, pwr_down_o is high for exactly F+2 ticks.
- R6: A low sample of wake_i during the filter state restarts the consecutive-sample count from zero, and the block stays in power-down.
- R7: After the filter passes, pwr_down_o drops and sys_rst_no is held low for exactly T ticks, or for 1 tick when T is 0. The block then returns to running with sys_rst_no high.
- R8: The pin-control register at offset 0x40 keeps bits 4, 2 and 1 and reads all other bits as 0. clk32_oe_o is 1 only when bits 2 and 1 are both set. pad_pull_dis_o follows bit 4. Writing 0 turns both outputs off.
- R9: Writes to unmapped offsets change no register, and reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_slow_i | input | 1 | 32 kHz oscillator clock; all logic runs on it |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe, one tick per write |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Combinational read data for reg_addr_i |
| wake_i | input | 1 | Wakeup pin, active high |
| pwr_down_o | output | 1 | High while hibernating or filtering the wakeup pin |
| sys_rst_no | output | 1 | Active-low system reset issued after wakeup |
| clk32_oe_o | output | 1 | Enable for the 32 kHz clock on its output pin |
| pad_pull_dis_o | output | 1 | Disables the pull-up on the clock pin |

## Verification
The embedded assertions check the properties that hold on every tick. The hibernate state always passes to the filter state after one tick. A low wakeup sample always leaves the block filtering with a cleared count. A running block stays running unless it receives a command. Power-down only ends into reset. Reserved register bits always read zero, and the clock output only turns on after a write to its register. The bench scenarios cover what a single-tick property cannot. These are the exact power-down and reset durations for given F and T, restarts after glitches on the wakeup pin, commands that are ignored in the middle of a sequence, and register read-back for random data.

// File: rtl/hws_pkg.sv
package hws_pkg;
   typedef enum logic [1:0] {
      ST_RUN   = 2'd0,
      ST_HIB   = 2'd1,
      ST_WFILT = 2'd2,
      ST_RHOLD = 2'd3
   } hws_state_t;
endpackage

// File: rtl/hws_regs.sv
module hws_regs #(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32,
   parameter logic [ADDR_W-1:0] OFF_HIB  = 'h20,
   parameter logic [ADDR_W-1:0] OFF_FILT = 'h24,
   parameter logic [ADDR_W-1:0] OFF_RST  = 'h28,
   parameter logic [ADDR_W-1:0] OFF_CKP  = 'h40,
   parameter int FILT_LO   = 5,
   parameter int FILT_HI   = 15,
   parameter int RST_LO    = 5,
   parameter int RST_HI    = 11,
   parameter int CKP_PULL  = 4,
   parameter int CKP_EN_LO = 1,
   parameter int CKP_EN_HI = 2,
   parameter bit PIN_CTRL  = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              hib_req_o,
   output logic [FILT_HI:0]  filt_ticks_o,
   output logic [RST_HI:0]   rst_ticks_o,
   output logic              clk_en_o,
   output logic              pull_dis_o
);
   localparam int FILT_W = FILT_HI - FILT_LO + 1;
   localparam int RST_W  = RST_HI - RST_LO + 1;
   localparam logic [DATA_W-1:0] FILT_MASK = DATA_W'(((64'd1 << FILT_W) - 64'd1) << FILT_LO);
   localparam logic [DATA_W-1:0] RST_MASK  = DATA_W'(((64'd1 << RST_W) - 64'd1) << RST_LO);

   if (FILT_HI >= DATA_W || RST_HI >= DATA_W || CKP_PULL >= DATA_W || CKP_EN_HI >= DATA_W) begin : g_bad_width
      $error("hws_regs: field beyond data width");
   end
   if (FILT_LO < 1 || RST_LO < 1 || FILT_HI < FILT_LO || RST_HI < RST_LO) begin : g_bad_field
      $error("hws_regs: count fields must be non-empty and start above bit 0");
   end

   logic [FILT_W-1:0] filt_q;
   logic [RST_W-1:0]  rst_q;
   logic [DATA_W-1:0] ckp_rd;

   logic sel_filt, sel_rst, sel_ckp;
   assign sel_filt = we_i && (addr_i == OFF_FILT);
   assign sel_rst  = we_i && (addr_i == OFF_RST);
   assign sel_ckp  = we_i && (addr_i == OFF_CKP);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         filt_q <= '0;
         rst_q  <= '0;
      end else begin
         if (sel_filt) filt_q <= wdata_i[FILT_HI:FILT_LO];
         if (sel_rst)  rst_q  <= wdata_i[RST_HI:RST_LO];
      end
   end

   assign hib_req_o    = we_i && (addr_i == OFF_HIB) && wdata_i[0];
   assign filt_ticks_o = {filt_q, {FILT_LO{1'b0}}};
   assign rst_ticks_o  = {rst_q, {RST_LO{1'b0}}};

   if (PIN_CTRL) begin : g_pin
      logic                           pull_q;
      logic [CKP_EN_HI-CKP_EN_LO:0]   en_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            pull_q <= 1'b0;
            en_q   <= '0;
         end else if (sel_ckp) begin
            pull_q <= wdata_i[CKP_PULL];
            en_q   <= wdata_i[CKP_EN_HI:CKP_EN_LO];
         end
      end

      assign clk_en_o   = &en_q;
      assign pull_dis_o = pull_q;

      always_comb begin
         ckp_rd = '0;
         ckp_rd[CKP_PULL] = pull_q;
         ckp_rd[CKP_EN_HI:CKP_EN_LO] = en_q;
      end

      // R8: the clock output only turns on after a write to its register
      p_clk_on_by_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $rose(clk_en_o) |-> $past(we_i && addr_i == OFF_CKP));
   end else begin : g_nopin
      assign clk_en_o   = 1'b0;
      assign pull_dis_o = 1'b0;
      assign ckp_rd     = '0;
   end

   always_comb begin
      rdata_o = '0;
      if (addr_i == OFF_FILT)      rdata_o[FILT_HI:FILT_LO] = filt_q;
      else if (addr_i == OFF_RST)  rdata_o[RST_HI:RST_LO]   = rst_q;
      else if (addr_i == OFF_CKP)  rdata_o = ckp_rd;
   end

   // R3: reserved bits of the filter register read as zero
   p_filt_reserved_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (addr_i == OFF_FILT) |-> ((rdata_o & ~FILT_MASK) == '0));
   // R4: reserved bits of the reset-time register read as zero
   p_rst_reserved_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (addr_i == OFF_RST) |-> ((rdata_o & ~RST_MASK) == '0));
endmodule

// File: rtl/hws_fsm.sv
module hws_fsm
   import hws_pkg::*;
#(
   parameter int FCNT_W = 16,
   parameter int RCNT_W = 12
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              hib_req_i,
   input  logic              wake_i,
   input  logic [FCNT_W-1:0] filt_ticks_i,
   input  logic [RCNT_W-1:0] rst_ticks_i,
   output logic              pwr_down_o,
   output logic              sys_rst_no
);
   if (FCNT_W < 2 || RCNT_W < 2) begin : g_bad_cnt
      $error("hws_fsm: counter widths too small");
   end

   hws_state_t        st_q;
   logic [FCNT_W-1:0] fcnt_q;
   logic [RCNT_W-1:0] rcnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q   <= ST_RUN;
         fcnt_q <= '0;
         rcnt_q <= '0;
      end else begin
         unique case (st_q)
            ST_RUN: begin
               if (hib_req_i) st_q <= ST_HIB;
            end
            ST_HIB: begin
               st_q   <= ST_WFILT;
               fcnt_q <= '0;
            end
            ST_WFILT: begin
               if (!wake_i) begin
                  fcnt_q <= '0;
               end else if (fcnt_q >= filt_ticks_i) begin
                  st_q   <= ST_RHOLD;
                  rcnt_q <= RCNT_W'(1);
               end else begin
                  fcnt_q <= fcnt_q + 1'b1;
               end
            end
            ST_RHOLD: begin
               if (rcnt_q >= rst_ticks_i) st_q <= ST_RUN;
               else                       rcnt_q <= rcnt_q + 1'b1;
            end
            default: st_q <= ST_RUN;
         endcase
      end
   end

   assign pwr_down_o = (st_q == ST_HIB) || (st_q == ST_WFILT);
   assign sys_rst_no = (st_q != ST_RHOLD);

   // R5: hibernate always hands over to the filter after one tick
   p_hib_to_filt_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == ST_HIB) |=> (st_q == ST_WFILT));
   // R6: a low wake sample restarts the filter and keeps power down
   p_low_restarts_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == ST_WFILT && !wake_i) |=> (st_q == ST_WFILT && fcnt_q == '0 && pwr_down_o));
   // R2: without a command a running block keeps running
   p_run_holds_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == ST_RUN && !hib_req_i) |=> (!pwr_down_o && sys_rst_no));
   // R7: power-down only ends into the reset pulse
   p_pd_ends_in_reset_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(pwr_down_o) |-> !sys_rst_no);
endmodule

// File: rtl/hib_wake_seq.sv
module hib_wake_seq #(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 32,
   parameter int FILT_LO   = 5,
   parameter int FILT_HI   = 15,
   parameter int RST_LO    = 5,
   parameter int RST_HI    = 11,
   parameter bit PIN_CTRL  = 1'b1
) (
   input  logic              clk_slow_i,
   input  logic              rst_ni,
   input  logic              reg_we_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic [DATA_W-1:0] reg_wdata_i,
   output logic [DATA_W-1:0] reg_rdata_o,
   input  logic              wake_i,
   output logic              pwr_down_o,
   output logic              sys_rst_no,
   output logic              clk32_oe_o,
   output logic              pad_pull_dis_o
);
   localparam int FCNT_W = FILT_HI + 1;
   localparam int RCNT_W = RST_HI + 1;

   logic              hib_req;
   logic [FCNT_W-1:0] filt_ticks;
   logic [RCNT_W-1:0] rst_ticks;

   hws_regs #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .FILT_LO  (FILT_LO),
      .FILT_HI  (FILT_HI),
      .RST_LO   (RST_LO),
      .RST_HI   (RST_HI),
      .PIN_CTRL (PIN_CTRL)
   ) u_regs (
      .clk_i        (clk_slow_i),
      .rst_ni       (rst_ni),
      .we_i         (reg_we_i),
      .addr_i       (reg_addr_i),
      .wdata_i      (reg_wdata_i),
      .rdata_o      (reg_rdata_o),
      .hib_req_o    (hib_req),
      .filt_ticks_o (filt_ticks),
      .rst_ticks_o  (rst_ticks),
      .clk_en_o     (clk32_oe_o),
      .pull_dis_o   (pad_pull_dis_o)
   );

   hws_fsm #(
      .FCNT_W (FCNT_W),
      .RCNT_W (RCNT_W)
   ) u_fsm (
      .clk_i        (clk_slow_i),
      .rst_ni       (rst_ni),
      .hib_req_i    (hib_req),
      .wake_i       (wake_i),
      .filt_ticks_i (filt_ticks),
      .rst_ticks_i  (rst_ticks),
      .pwr_down_o   (pwr_down_o),
      .sys_rst_no   (sys_rst_no)
   );
endmodule

// File: tb/sim_hib_wake_seq.sv
module sim_hib_wake_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        we = 1'b0;
   logic        wake = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        pd, srn, ckoe, pull;

   int n_tests = 0;
   int n_fail  = 0;

   int e_ph  = 0;
   int e_cnt = 0;
   int mF    = 0;
   int mR    = 0;

   always #5 clk = ~clk;

   hib_wake_seq u0 (
      .clk_slow_i     (clk),
      .rst_ni         (rst_n),
      .reg_we_i       (we),
      .reg_addr_i     (addr),
      .reg_wdata_i    (wdata),
      .reg_rdata_o    (rdata),
      .wake_i         (wake),
      .pwr_down_o     (pd),
      .sys_rst_no     (srn),
      .clk32_oe_o     (ckoe),
      .pad_pull_dis_o (pull)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      addr = a; wdata = d; we = 1'b1;
      @(posedge clk); @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(logic [7:0] a, output logic [31:0] d);
      addr = a;
      #1 d = rdata;
   endtask

   function automatic int exp_low_ticks(int t);
      return (t == 0) ? 1 : t;
   endfunction

   function automatic void model_next(logic pin, logic w, logic [7:0] a, logic [31:0] d);
      case (e_ph)
         0: if (w && a == 8'h20 && d[0]) e_ph = 1;
         1: begin e_ph = 2; e_cnt = 0; end
         2: begin
            if (!pin)              e_cnt = 0;
            else if (e_cnt >= mF)  begin e_ph = 3; e_cnt = 1; end
            else                   e_cnt++;
         end
         default: begin
            if (e_cnt >= mR) e_ph = 0;
            else             e_cnt++;
         end
      endcase
   endfunction

   task automatic run_seq(int ff, int rf, int mode);
      int   pd_cnt = 0;
      int   rl_cnt = 0;
      logic prev_low = 1'b0;
      logic glitched = 1'b0;
      logic pin;
      string tag;
      wr(8'h24, (ff << 5) | ($urandom & 32'h1F));
      wr(8'h28, rf << 5);
      mF = ff * 32; mR = rf * 32; e_ph = 0; e_cnt = 0;
      for (int k = 0; k < 4000; k++) begin
         if (e_ph == 3)      tag = "R7";
         else if (e_ph == 0) tag = "R2";
         else if (prev_low)  tag = "R6";
         else                tag = "R5";
         check(tag, {31'd0, pd},  {31'd0, (e_ph == 1 || e_ph == 2)}, "pwr_down_o");
         check(tag, {31'd0, srn}, {31'd0, (e_ph != 3)},              "sys_rst_no");
         if (pd)  pd_cnt++;
         if (!srn) rl_cnt++;
         if (k > 0 && e_ph == 0) break;
         if (k == 0) begin
            we = 1'b1; addr = 8'h20; wdata = 32'h1;
         end else if ($urandom_range(7) == 0) begin
            we = 1'b1; addr = 8'h20; wdata = 32'h1;   // R2: ignored outside running
         end else begin
            we = 1'b0;
         end
         case (mode)
            0: pin = 1'b1;
            1: pin = (k > 300) ? 1'b1 : ($urandom_range(63) != 0);
            default: begin
               pin = 1'b1;
               if (!glitched && mF > 0 && e_ph == 2 && e_cnt == mF / 2) begin
                  pin = 1'b0;
                  glitched = 1'b1;
               end
            end
         endcase
         wake = pin;
         prev_low = (e_ph == 2) && !pin;
         model_next(pin, we, addr, wdata);
         @(posedge clk); @(negedge clk);
      end
      we = 1'b0; wake = 1'b0;
      check("R7", {31'd0, srn}, 32'd1, "back to running");
      if (mode == 0) begin
         check("R5", pd_cnt, ff * 32 + 2, "power-down ticks");
         check("R7", rl_cnt, exp_low_ticks(rf * 32), "reset low ticks");
      end
   endtask

   initial begin
      #2_000_000;
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] d, r;
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      check("R1", {31'd0, pd},   32'd0, "pwr_down_o");
      check("R1", {31'd0, srn},  32'd1, "sys_rst_no");
      check("R1", {31'd0, ckoe}, 32'd0, "clk32_oe_o");
      check("R1", {31'd0, pull}, 32'd0, "pad_pull_dis_o");
      rd(8'h24, r); check("R1", r, 32'd0, "filter reg");
      rd(8'h28, r); check("R1", r, 32'd0, "reset reg");
      rd(8'h40, r); check("R1", r, 32'd0, "pin reg");

      for (int i = 0; i < 6; i++) begin
         d = $urandom;
         wr(8'h24, d); rd(8'h24, r); check("R3", r, d & 32'h0000_FFE0, "filter readback");
         d = $urandom;
         wr(8'h28, d); rd(8'h28, r); check("R4", r, d & 32'h0000_0FE0, "reset readback");
         d = $urandom;
         wr(8'h40, d); rd(8'h40, r); check("R8", r, d & 32'h0000_0016, "pin readback");
         check("R8", {31'd0, ckoe}, {31'd0, d[2] & d[1]}, "clk32_oe_o");
         check("R8", {31'd0, pull}, {31'd0, d[4]},        "pad_pull_dis_o");
      end

      wr(8'h40, 32'h16); check("R8", {31'd0, ckoe}, 32'd1, "clk on");
      check("R8", {31'd0, pull}, 32'd1, "pull off");
      wr(8'h40, 32'h0);  check("R8", {31'd0, ckoe}, 32'd0, "clk off by zero");
      check("R8", {31'd0, pull}, 32'd0, "pull restored by zero");
      wr(8'h40, 32'h2);  check("R8", {31'd0, ckoe}, 32'd0, "single enable bit");
      wr(8'h40, 32'h0);

      // R9: unmapped offsets
      wr(8'h24, 32'hFFFF_FFFF);
      wr(8'h28, 32'h0000_0FE0);
      wr(8'h30, $urandom);
      wr(8'h2C, $urandom);
      rd(8'h30, r); check("R9", r, 32'd0, "unmapped read");
      rd(8'h24, r); check("R9", r, 32'h0000_FFE0, "filter kept");
      rd(8'h28, r); check("R9", r, 32'h0000_0FE0, "reset kept");
      rd(8'h20, r); check("R2", r, 32'd0, "command reads zero");

      // R2: bit 0 clear has no effect
      wr(8'h20, 32'hFFFF_FFFE);
      check("R2", {31'd0, pd}, 32'd0, "no hibernate with bit0 clear");
      @(negedge clk);
      check("R2", {31'd0, pd}, 32'd0, "still running");

      // directed corner cases: zero counts, held pin, glitch
      run_seq(0, 0, 0);
      run_seq(1, 1, 0);
      run_seq(3, 2, 0);
      run_seq(0, 3, 0);
      run_seq(2, 1, 2);
      run_seq(4, 0, 2);
      run_seq(1, 0, 1);

      for (int i = 0; i < 8; i++) begin
         int m;
         m = $urandom_range(2);
         if (m == 1) run_seq($urandom_range(3), $urandom_range(3), m);
         else        run_seq($urandom_range(7), $urandom_range(3), m);
      end

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule